// File: doc/BRIEF.md
# Gate-Level Signed Magnitude Unit

This block turns a signed two's-complement word into its magnitude using only plain gates: NOT, AND, OR and XOR. It contains no adder and no incrementer. The sign bit alone decides whether the word is changed.

When the word is negative, the block scans from the least significant end. Every bit up to and including the first 1 passes through unchanged, and every bit above that point is inverted. The logic is purely combinational. The default width is 4 bits.

The block is meant as a small leaf inside a datapath. A parent uses it where a magnitude is needed within the same cycle and a carry chain is unwelcome.

Top module: `abs_gate`

## Requirements
- R1: When the sign bit `x_i[W-1]` is 0, `y_o` equals `x_i` bit for bit.
- R2: Output bit 0 always equals input bit 0, whatever the sign.
- R3: When the sign bit is 1, every output bit from bit 0 up to and including the lowest input bit that is 1 equals the matching input bit.
- R4: When the sign bit is 1, every output bit above the lowest set input bit is the inverse of the matching input bit.
- R5: The most negative input (sign bit 1, all other bits 0; 4'b1000 at W=4) gives back the same pattern, because its magnitude cannot be held in W bits.
- R6: For every input, `y_o` equals the arithmetic absolute value of `x_i`, read as signed, truncated to W bits.
- R7: The output sign bit `y_o[W-1]` is 1 only for the most negative input.
- R8: The block holds no state. `y_o` follows a change of `x_i` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | W (4) | Signed two's-complement operand |
| y_o | output | W (4) | Magnitude of `x_i`, truncated to W bits |

## Verification
Every result is combinational, so it is due zero cycles after the stimulus. The bench drives the operand on the falling clock edge and samples `y_o` half a period later, on the next rising edge, with no register in between. A separate check for R8 applies a new operand and samples 1 ns later, inside the same cycle. The bench sweeps all 16 operands and computes the expected magnitude arithmetically.

// File: rtl/abs_pkg.sv
package abs_pkg;
  localparam int unsigned ABS_DEF_W = 4;
endpackage

// File: rtl/abs_prefix_or.sv
// pre_o[k] = OR of in_i[k-1:0]; pre_o[0] = 0
module abs_prefix_or #(
  parameter int unsigned W = abs_pkg::ABS_DEF_W
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] pre_o
);
  assign pre_o[0] = 1'b0;
  for (genvar k = 1; k < W; k++) begin : g_chain
    assign pre_o[k] = pre_o[k-1] | in_i[k-1];
  end
endmodule

// File: rtl/abs_flip_gate.sv
module abs_flip_gate #(
  parameter int unsigned W = abs_pkg::ABS_DEF_W
) (
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] seen_i,
  input  logic         neg_i,
  output logic [W-1:0] out_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    logic flip;
    assign flip     = neg_i & seen_i[k];
    assign out_o[k] = in_i[k] ^ flip;
  end
endmodule

// File: rtl/abs_gate.sv
module abs_gate #(
  parameter int unsigned W = abs_pkg::ABS_DEF_W
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned SGN = W - 1;

  logic [W-1:0] seen;

  abs_prefix_or #(.W(W)) u_pre (
    .in_i  (x_i),
    .pre_o (seen)
  );

  abs_flip_gate #(.W(W)) u_flip (
    .in_i   (x_i),
    .seen_i (seen),
    .neg_i  (x_i[SGN]),
    .out_o  (y_o)
  );
endmodule

// File: rtl/abs_gate_chk.sv
module abs_gate_chk #(
  parameter int unsigned W = abs_pkg::ABS_DEF_W
) (
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_o
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    if (!$isunknown(x_i)) begin
      p_pos_pass_r1: assert (x_i[W-1] || (y_o == x_i));
      p_lsb_keep_r2: assert (y_o[0] == x_i[0]);
      p_min_self_r5: assert ((x_i != MINV) || (y_o == MINV));
      p_abs_val_r6:  assert (y_o == (x_i[W-1] ? (~x_i + 1'b1) : x_i));
      p_sign_low_r7: assert (!y_o[W-1] || (x_i == MINV));
    end
  end
endmodule

bind abs_gate abs_gate_chk #(.W(W)) u_chk (.x_i(x_i), .y_o(y_o));

// File: tb/abs_gate_tb.sv
module abs_gate_tb;
  localparam int W = 4;

  logic clk;
  logic rst_ni;
  logic [W-1:0] x;
  logic [W-1:0] y;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  abs_gate #(.W(W)) u_dut (.x_i(x), .y_o(y));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s x=%b actual=%b expected=%b", req, x, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    x = '0;
    repeat (2) @(posedge clk);
    check("R1 reset state", y, '0);
    rst_ni = 1'b1;

    for (int v = 0; v < (1 << W); v++) begin
      @(negedge clk);
      x = v[W-1:0];
      @(posedge clk);
      begin
        int sv;
        int mag;
        int low;
        logic [W-1:0] e;
        logic [W-1:0] msk;
        sv  = (v >= (1 << (W-1))) ? v - (1 << W) : v;
        mag = (sv < 0) ? -sv : sv;
        e   = mag[W-1:0];
        low = W;
        for (int b = W - 1; b >= 0; b--) if (v[b]) low = b;
        msk = '0;
        for (int b = 0; b < W; b++) if (b <= low) msk[b] = 1'b1;
        check("R6 magnitude", y, e);
        check("R2 bit0", {{(W-1){1'b0}}, y[0]}, {{(W-1){1'b0}}, x[0]});
        check("R7 sign", {{(W-1){1'b0}}, y[W-1]}, {{(W-1){1'b0}}, (v == (1 << (W-1)))});
        if (sv >= 0) begin
          check("R1 passthrough", y, x);
        end else begin
          check("R3 low copy", y & msk, x & msk);
          check("R4 high invert", y & ~msk, ~x & ~msk);
          if (v == (1 << (W-1))) check("R5 most negative", y, x);
        end
      end
    end

    @(negedge clk);
    x = 4'b1010;
    #1;
    check("R8 same cycle", y, 4'b0110);
    x = 4'b1111;
    #1;
    check("R8 same cycle", y, 4'b0001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule